// File: doc/BRIEF.md
# Multiframe Phase Counter

This block produces the local multiframe timing reference of a multi-lane serial converter link. It sits in the link clock domain, where each link-clock cycle moves four octets per lane. A multiframe holds K frames of F octets each, so one multiframe lasts F·K/4 link-clock cycles. The block counts link-clock cycles across that span and wraps. It also emits a pulse at the start of every multiframe.

An external system reference strobe is brought into the link domain through a two-flop synchronizer, and its rising edges are detected. The first detected edge pins the counter phase and raises an aligned flag. Later edges are compared against the running phase. An edge that lands on a multiframe boundary leaves the count alone. An edge that lands anywhere else pulls the counter back to zero and latches a phase-error flag. This follows from the rule that the strobe period must be a whole number of multiframes.

Top module: `mfc_timebase`

## Requirements
- R1: The count wraps every F·K/4 link-clock cycles, so two consecutive boundary pulses are exactly F·K/4 cycles apart when no realignment happens.
- R2: The count output runs 0, 1, …, F·K/4 − 1 and returns to 0 on the following clock, advancing by one on every clock that does not realign it.
- R3: Only a low-to-high transition of the reference strobe acts. Holding the strobe high for many cycles gives a single event and leaves the count advancing normally afterwards.
- R4: The aligned output is 0 after reset. It becomes 1 on the first detected strobe edge and stays 1 until reset.
- R5: If the strobe is low when sampled at rising clock edge n−1 and high when sampled at edge n, and that event realigns, the count output reads 0 after clock edge n+2.
- R6: After alignment, a strobe edge whose arrival would not already bring the count to 0 on the next clock sets the phase-error output, which stays 1 until reset. A strobe whose period is a whole multiple of the multiframe keeps it at 0.
- R7: The boundary output is 1 in exactly those cycles in which the count output is 0.
- R8: With the synchronous reset high at a clock edge, the count, aligned and phase-error outputs are 0 after that edge, and the synchronizer history is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| sysref_i | input | 1 | Asynchronous system reference strobe |
| mf_count_o | output | CNT_W | Link-clock position inside the current multiframe |
| mf_edge_o | output | 1 | High while the count is 0 (multiframe start) |
| aligned_o | output | 1 | Set once the first strobe edge has been seen |
| phase_err_o | output | 1 | Sticky flag: a strobe edge arrived off the multiframe boundary |

## Verification
The bench builds the block with F=3 and K=32, so the multiframe lasts 24 link clocks. That length is not a power of two, so the wrap must come from an explicit compare rather than from counter overflow. A 24-cycle span also leaves room for strobe periods of 48 cycles (in phase) and 53 cycles (off phase), which exercise both outcomes of the phase comparison. The long span makes it possible to hold the strobe high across more than a full multiframe.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

    // Link-clock cycles per multiframe: F*K octets, four octets per clock.
    function automatic int unsigned mf_cycles(input int unsigned f_oct, input int unsigned k_frm);
        return (f_oct * k_frm) / 4;
    endfunction

    // Width of a counter that must hold 0 .. len-1.
    function automatic int unsigned cnt_width(input int unsigned len);
        return (len <= 2) ? 1 : $clog2(len);
    endfunction

endpackage

// File: rtl/mfc_sysref_sync.sv
module mfc_sysref_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sysref_i,
    output logic rise_o
);
    localparam int unsigned HIST = STAGES + 1;

    typedef struct packed {
        logic [HIST-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[HIST-2:0], sysref_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Edge is formed from the last synchronized sample and the one before it.
    assign rise_o = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];

    generate
        if (STAGES < 2) begin : g_bad_stages
            $error("mfc_sysref_sync needs at least two synchronizer stages");
        end
    endgenerate

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o) else $error("strobe edge lasted two cycles"); // R3

endmodule

// File: rtl/mfc_phase_cnt.sv
module mfc_phase_cnt
    import mfc_pkg::*;
#(
    parameter  int unsigned MF_LEN = 8,
    localparam int unsigned CW     = cnt_width(MF_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    output logic [CW-1:0] count_o,
    output logic          aligned_o,
    output logic          phase_err_o
);
    localparam logic [CW-1:0] LAST = CW'(MF_LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          aligned;
        logic          err;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic [CW-1:0] cnt_free;
    logic          on_phase;

    always_comb begin
        cnt_free = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
        on_phase = (cnt_free == '0);
        st_d     = st_q;
        st_d.cnt = cnt_free;
        if (rise_i) begin
            if (!st_q.aligned) begin
                st_d.cnt     = '0;
                st_d.aligned = 1'b1;
            end else if (!on_phase) begin
                st_d.cnt = '0;
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_o     = st_q.cnt;
    assign aligned_o   = st_q.aligned;
    assign phase_err_o = st_q.err;

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        count_o <= LAST) else $error("count beyond multiframe"); // R2
    AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
        aligned_o |=> aligned_o) else $error("aligned dropped"); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        phase_err_o |=> phase_err_o) else $error("phase error dropped"); // R6
    AST_ERR_AFTER_ALIGN: assert property (@(posedge clk) disable iff (rst)
        phase_err_o |-> aligned_o) else $error("error without alignment"); // R6
    AST_REALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rise_i && (!aligned_o || !on_phase)) |=> (count_o == '0 && aligned_o))
        else $error("realign did not zero count"); // R5

endmodule

// File: rtl/mfc_timebase.sv
module mfc_timebase
    import mfc_pkg::*;
#(
    parameter  int unsigned F_OCTETS  = 2,
    parameter  int unsigned K_FRAMES  = 16,
    localparam int unsigned MF_LEN    = mf_cycles(F_OCTETS, K_FRAMES),
    localparam int unsigned CNT_W     = cnt_width(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sysref_i,
    output logic [CNT_W-1:0] mf_count_o,
    output logic             mf_edge_o,
    output logic             aligned_o,
    output logic             phase_err_o
);
    generate
        if ((F_OCTETS * K_FRAMES) % 4 != 0) begin : g_bad_fk
            $error("F*K must be a multiple of four octets");
        end
        if (MF_LEN < 2) begin : g_short_mf
            $error("multiframe must span at least two link clocks");
        end
    endgenerate

    logic rise;

    mfc_sysref_sync #(
        .STAGES (2)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sysref_i (sysref_i),
        .rise_o   (rise)
    );

    mfc_phase_cnt #(
        .MF_LEN (MF_LEN)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .rise_i      (rise),
        .count_o     (mf_count_o),
        .aligned_o   (aligned_o),
        .phase_err_o (phase_err_o)
    );

    assign mf_edge_o = (mf_count_o == '0);

    AST_ERR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!phase_err_o && !rise) |=> !phase_err_o) else $error("error without strobe"); // R6

endmodule

// File: tb/sim_mfc_timebase.sv
module sim_mfc_timebase;
    localparam int unsigned FO  = 3;
    localparam int unsigned KF  = 32;
    localparam int unsigned MFL = FO * KF / 4;
    localparam int unsigned CW  = $clog2(MFL);

    typedef struct {
        int   cnt;
        logic edge_v;
        logic al;
        logic er;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sysref = 1'b0;
    logic [CW-1:0] mf_count;
    logic          mf_edge, aligned, phase_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    mfc_timebase #(.F_OCTETS(FO), .K_FRAMES(KF)) u0 (
        .clk(clk), .rst(rst), .sysref_i(sysref),
        .mf_count_o(mf_count), .mf_edge_o(mf_edge),
        .aligned_o(aligned), .phase_err_o(phase_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference predictor: pushes one expected item per clock edge.
    logic [2:0] m_sh = '0;
    int   m_cnt = 0;
    logic m_al = 0, m_er = 0;
    always @(posedge clk) begin
        int nxt;
        logic rise;
        if (rst) begin
            m_sh = '0; m_cnt = 0; m_al = 0; m_er = 0;
        end else begin
            rise = m_sh[1] & ~m_sh[2];
            nxt  = (m_cnt == MFL - 1) ? 0 : m_cnt + 1;
            if (rise) begin
                if (!m_al) begin nxt = 0; m_al = 1; end
                else if (nxt != 0) begin nxt = 0; m_er = 1; end
            end
            m_cnt = nxt;
            m_sh  = {m_sh[1:0], sysref};
        end
        exp_q.push_back('{m_cnt, (m_cnt == 0), m_al, m_er});
    end

    // Monitor: compares every cycle away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            chk("R2 count",     int'(mf_count),  e.cnt);
            chk("R7 boundary",  int'(mf_edge),   int'(e.edge_v));
            chk("R4 aligned",   int'(aligned),   int'(e.al));
            chk("R6 phase_err", int'(phase_err), int'(e.er));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic train(input int period, input int n, input int width);
        for (int i = 0; i < n; i++) begin
            sysref = 1'b1;
            repeat (width) @(negedge clk);
            sysref = 1'b0;
            repeat (period - width) @(negedge clk);
        end
    endtask

    task automatic spacing(input string tag);
        int gap = 0;
        while (!mf_edge) @(negedge clk);
        @(negedge clk); gap = 1;
        while (!mf_edge) begin @(negedge clk); gap++; end
        chk(tag, gap, MFL);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R8 reset count",   int'(mf_count),  0);
        chk("R8 reset aligned", int'(aligned),   0);
        chk("R8 reset err",     int'(phase_err), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        // First strobe: count must read 0 after the third edge (R5).
        sysref = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 count after first edge", int'(mf_count), 0);
        chk("R4 aligned after first edge", int'(aligned), 1);
        sysref = 1'b0;
        repeat (45) @(negedge clk);
        train(2 * MFL, 2, 4);                 // in phase
        chk("R6 no error in phase", int'(phase_err), 0);
        spacing("R1 multiframe spacing");
        train(2 * MFL, 1, 4);
        train(2 * MFL + 5, 2, 4);             // off phase
        chk("R6 error off phase", int'(phase_err), 1);
        // Level held high: single event, then free running (R3).
        repeat (7) @(negedge clk);
        sysref = 1'b1;
        repeat (10) @(negedge clk);
        spacing("R3 spacing with strobe held");
        spacing("R3 second spacing with strobe held");
        sysref = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 count cleared",   int'(mf_count),  0);
        chk("R8 aligned cleared", int'(aligned),   0);
        chk("R8 err cleared",     int'(phase_err), 0);
        rst = 1'b0;
        repeat (13) @(negedge clk);
        train(3 * MFL, 2, 2);
        chk("R6 clean after reset", int'(phase_err), 0);
        chk("R4 realigned after reset", int'(aligned), 1);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule